// File: doc/BRIEF.md
# Two-Thread Owner-Tagged Micro-Op Line Cache

This block is a small set-associative store of decoded micro-operation lines shared by two hardware threads. Each thread has its own request strobe and instruction pointer. A front arbiter picks at most one thread per cycle. The picked thread's pointer is looked up, and the result appears on registered outputs one cycle later. Every line records the thread that wrote it. A lookup only hits when the address tag matches and the stored owner equals the requesting thread, so two threads that use the same pointer never share a line.

A lookup that misses puts the requesting thread into a stalled state. A stalled thread gives up the lookup slot until a line is filled on its behalf through the fill port. While one thread is stalled, the other thread gets every slot. The next memory level, which fetches and decodes the line, is outside this block: whatever owns the fill port writes the decoded line back.

Replacement is least-recently-used within a set, and the order is shared by both threads, so one thread can hold more ways of a set than the other. Empty ways are always used before any valid line is evicted.

Top module: `dual_thread_uop_cache`

## Requirements
- R1: While `rst` is high, and on the cycle after it is released, `grant` is 2'b00 and `out_hit` is 0. Reset invalidates every line. The first contention after reset is won by thread 0.
- R2: If both threads request in a cycle and neither is stalled, the thread not granted most recently wins, so access alternates cycle by cycle. `grant` is one-hot or zero: bit 0 is thread 0 and bit 1 is thread 1.
- R3: If exactly one eligible thread requests, it is granted in every such cycle. If no eligible thread requests, `grant` is 2'b00.
- R4: A granted lookup that misses stalls its thread. A stalled thread's requests are ignored, and the other thread takes every slot. A fill with `fill_tid` equal to that thread releases the stall from the next cycle on.
- R5: A lookup hits only if a valid line in the indexed set has the requesting thread as owner and a matching tag. The same pointer from the other thread misses.
- R6: `grant`, `out_hit` and `out_data` for a request presented in cycle N appear after the clock edge that ends cycle N. `out_data` carries the hit line's data, and is zero on a miss.
- R7: The set index is ip[OFFS_W +: log2(SETS)], and the tag is every bit above the index. Lines in different sets do not disturb each other.
- R8: A fill into a set with an empty way writes the lowest-numbered empty way. No valid line is evicted while a way is empty. A set holds up to WAYS lines (8 by default).
- R9: In a full set, a fill evicts the least recently used line, whichever thread owns it. Both hits and fills mark a line as most recently used.
- R10: A fill whose owner and pointer match a line already present overwrites that line in place. It does not take another way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req0 | input | 1 | Thread 0 lookup request |
| ip0 | input | IP_W | Thread 0 instruction pointer |
| req1 | input | 1 | Thread 1 lookup request |
| ip1 | input | IP_W | Thread 1 instruction pointer |
| fill_vld | input | 1 | Write a line this cycle |
| fill_tid | input | 1 | Owner thread of the written line |
| fill_ip | input | IP_W | Pointer of the written line |
| fill_data | input | DATA_W | Decoded line contents |
| grant | output | 2 | One-hot thread served by the previous cycle's lookup |
| out_hit | output | 1 | Previous cycle's lookup hit |
| out_data | output | DATA_W | Data of the hit line, zero on miss |

## Verification
The bench builds the cache with 4 sets of 4 ways, a 16-bit pointer and 16-bit data. With four ways, a short sequence of fills fills set 0 completely. This lets the bench reach empty-way allocation, a full set, and eviction of the other thread's line through the shared LRU order in under a dozen cycles. With only four sets, pointers 0x0010 and 0x0014 land in neighbouring sets, which makes the index split easy to see. The 16-bit pointer keeps the stimulus table short.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic {THR0 = 1'b0, THR1 = 1'b1} thr_e;
endpackage

// File: rtl/tc_arbiter.sv
module tc_arbiter
  import tc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] req,
  input  logic [1:0] stall,
  output logic       gnt_vld,
  output thr_e       gnt_tid,
  output logic       last_q
);
  logic [1:0] elig;

  assign elig = req & ~stall;

  always_comb begin
    gnt_vld = |elig;
    unique case (elig)
      2'b11:   gnt_tid = last_q ? THR0 : THR1;
      2'b10:   gnt_tid = THR1;
      default: gnt_tid = THR0;
    endcase
  end

  // last_q = 1 after reset so that thread 0 wins the first tie
  always_ff @(posedge clk) begin
    if (rst)          last_q <= 1'b1;
    else if (gnt_vld) last_q <= gnt_tid;
  end
endmodule

// File: rtl/tc_lru.sv
module tc_lru #(
  parameter int WAYS  = 8,
  parameter int AW    = $clog2(WAYS),
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][AW-1:0] ages,
  input  logic                    touch_vld,
  input  logic [WAY_W-1:0]        touch_way,
  output logic [WAYS-1:0][AW-1:0] ages_nxt,
  output logic [WAY_W-1:0]        lru_way
);
  logic [AW-1:0] ref_age;

  assign ref_age = ages[touch_way];

  // age 0 is most recent, WAYS-1 is the eviction candidate
  always_comb begin
    for (int i = 0; i < WAYS; i++) begin
      if (!touch_vld)                  ages_nxt[i] = ages[i];
      else if (WAY_W'(i) == touch_way) ages_nxt[i] = '0;
      else if (ages[i] < ref_age)      ages_nxt[i] = ages[i] + AW'(1);
      else                             ages_nxt[i] = ages[i];
    end
  end

  always_comb begin
    lru_way = '0;
    for (int i = 0; i < WAYS; i++)
      if (ages[i] == AW'(WAYS - 1)) lru_way = WAY_W'(i);
  end
endmodule

// File: rtl/dual_thread_uop_cache.sv
module dual_thread_uop_cache
  import tc_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int WAYS   = 8,
  parameter int IP_W   = 32,
  parameter int OFFS_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req0,
  input  logic [IP_W-1:0]   ip0,
  input  logic              req1,
  input  logic [IP_W-1:0]   ip1,
  input  logic              fill_vld,
  input  logic              fill_tid,
  input  logic [IP_W-1:0]   fill_ip,
  input  logic [DATA_W-1:0] fill_data,
  output logic [1:0]        grant,
  output logic              out_hit,
  output logic [DATA_W-1:0] out_data
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int AW    = $clog2(WAYS);
  localparam int TAG_W = IP_W - OFFS_W - IDX_W;

  // line storage
  logic [WAYS-1:0]         vld_q [SETS];
  logic [WAYS-1:0]         tid_q [SETS];
  logic [TAG_W-1:0]        tag_q [SETS][WAYS];
  logic [DATA_W-1:0]       dat_q [SETS][WAYS];
  logic [WAYS-1:0][AW-1:0] age_q [SETS];

  logic [1:0] stall_q;
  logic       gnt_vld;
  thr_e       gnt_tid;
  logic       arb_last;

  tc_arbiter i_arb (
    .clk    (clk),
    .rst    (rst),
    .req    ({req1, req0}),
    .stall  (stall_q),
    .gnt_vld(gnt_vld),
    .gnt_tid(gnt_tid),
    .last_q (arb_last)
  );

  // lookup side
  logic [IP_W-1:0]  l_ip;
  logic [IDX_W-1:0] l_set;
  logic [TAG_W-1:0] l_tag;
  logic [WAYS-1:0]  l_match;
  logic             l_hit;
  logic [WAY_W-1:0] l_way;

  assign l_ip  = (gnt_tid == THR1) ? ip1 : ip0;
  assign l_set = l_ip[OFFS_W +: IDX_W];
  assign l_tag = l_ip[IP_W-1 -: TAG_W];

  // fill side
  logic [IDX_W-1:0] f_set;
  logic [TAG_W-1:0] f_tag;
  logic [WAYS-1:0]  f_match;
  logic [WAY_W-1:0] f_hit_way, f_free_way, f_way, f_lru_way;
  logic             f_free_any;

  assign f_set = fill_ip[OFFS_W +: IDX_W];
  assign f_tag = fill_ip[IP_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign l_match[w] = vld_q[l_set][w] && (tid_q[l_set][w] == gnt_tid) &&
                        (tag_q[l_set][w] == l_tag);
    assign f_match[w] = vld_q[f_set][w] && (tid_q[f_set][w] == fill_tid) &&
                        (tag_q[f_set][w] == f_tag);
  end

  assign l_hit = gnt_vld && (|l_match);

  always_comb begin
    l_way      = '0;
    f_hit_way  = '0;
    f_free_way = '0;
    f_free_any = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (l_match[w]) l_way     = l_way     | WAY_W'(w);
      if (f_match[w]) f_hit_way = f_hit_way | WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[f_set][w]) begin
        f_free_way = WAY_W'(w);
        f_free_any = 1'b1;
      end
    end
  end

  // LRU: lookup touch first, then fill touch chained on the same set
  logic [WAYS-1:0][AW-1:0] l_age_nxt, f_age_in, f_age_nxt;

  tc_lru #(.WAYS(WAYS)) i_lru_look (
    .ages     (age_q[l_set]),
    .touch_vld(l_hit),
    .touch_way(l_way),
    .ages_nxt (l_age_nxt),
    .lru_way  ()
  );

  assign f_age_in = (l_hit && (l_set == f_set)) ? l_age_nxt : age_q[f_set];

  tc_lru #(.WAYS(WAYS)) i_lru_fill (
    .ages     (f_age_in),
    .touch_vld(fill_vld),
    .touch_way(f_way),
    .ages_nxt (f_age_nxt),
    .lru_way  (f_lru_way)
  );

  assign f_way = (|f_match) ? f_hit_way : (f_free_any ? f_free_way : f_lru_way);

  // valid bits, ages, stall flags
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= AW'(w);
      end
      stall_q <= '0;
    end else begin
      if (l_hit)    age_q[l_set] <= l_age_nxt;
      if (fill_vld) begin
        age_q[f_set]        <= f_age_nxt;
        vld_q[f_set][f_way] <= 1'b1;
      end
      for (int t = 0; t < 2; t++) begin
        if (fill_vld && (fill_tid == t[0]))
          stall_q[t] <= 1'b0;
        if (gnt_vld && (gnt_tid == thr_e'(t[0])) && !l_hit)
          stall_q[t] <= 1'b1;
      end
    end
  end

  // payload arrays without reset
  always_ff @(posedge clk) begin
    if (fill_vld) begin
      tid_q[f_set][f_way] <= fill_tid;
      tag_q[f_set][f_way] <= f_tag;
      dat_q[f_set][f_way] <= fill_data;
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      grant    <= '0;
      out_hit  <= 1'b0;
      out_data <= '0;
    end else begin
      grant    <= gnt_vld ? ((gnt_tid == THR1) ? 2'b10 : 2'b01) : 2'b00;
      out_hit  <= l_hit;
      out_data <= l_hit ? dat_q[l_set][l_way] : '0;
    end
  end
endmodule

// File: rtl/tc_checker.sv
module tc_checker (
  input logic       clk,
  input logic       rst,
  input logic       req0,
  input logic       req1,
  input logic [1:0] grant,
  input logic       out_hit,
  input logic [1:0] stall,
  input logic       last
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (grant == 2'b00 && !out_hit));

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_alt_to_t0_r2: assert property (@(posedge clk) disable iff (rst)
    (req0 && req1 && stall == 2'b00 && last) |=> grant == 2'b01);

  p_alt_to_t1_r2: assert property (@(posedge clk) disable iff (rst)
    (req0 && req1 && stall == 2'b00 && !last) |=> grant == 2'b10);

  p_single_t0_r3: assert property (@(posedge clk) disable iff (rst)
    (req0 && !stall[0] && !(req1 && !stall[1])) |=> grant == 2'b01);

  p_single_t1_r3: assert property (@(posedge clk) disable iff (rst)
    (req1 && !stall[1] && !(req0 && !stall[0])) |=> grant == 2'b10);

  p_stalled_t0_r4: assert property (@(posedge clk) disable iff (rst)
    stall[0] |=> !grant[0]);

  p_stalled_t1_r4: assert property (@(posedge clk) disable iff (rst)
    stall[1] |=> !grant[1]);

  p_miss_stalls_r4: assert property (@(posedge clk) disable iff (rst)
    (grant != 2'b00 && !out_hit) |-> ((stall & grant) == grant));

  p_hit_has_grant_r6: assert property (@(posedge clk) disable iff (rst)
    out_hit |-> grant != 2'b00);
endmodule

bind dual_thread_uop_cache tc_checker i_chk (
  .clk    (clk),
  .rst    (rst),
  .req0   (req0),
  .req1   (req1),
  .grant  (grant),
  .out_hit(out_hit),
  .stall  (stall_q),
  .last   (arb_last)
);

// File: tb/test_dual_thread_uop_cache.sv
`timescale 1ns/1ps
module test_dual_thread_uop_cache;
  localparam int IW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req0 = 1'b0, req1 = 1'b0;
  logic [IW-1:0] ip0 = '0, ip1 = '0;
  logic          fill_vld = 1'b0, fill_tid = 1'b0;
  logic [IW-1:0] fill_ip = '0;
  logic [DW-1:0] fill_data = '0;
  logic [1:0]    grant;
  logic          out_hit;
  logic [DW-1:0] out_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_thread_uop_cache #(
    .SETS(4), .WAYS(4), .IP_W(IW), .OFFS_W(2), .DATA_W(DW)
  ) i_dual_thread_uop_cache (
    .clk(clk), .rst(rst),
    .req0(req0), .ip0(ip0), .req1(req1), .ip1(ip1),
    .fill_vld(fill_vld), .fill_tid(fill_tid), .fill_ip(fill_ip), .fill_data(fill_data),
    .grant(grant), .out_hit(out_hit), .out_data(out_data)
  );

  typedef struct packed {
    logic          r0;
    logic [IW-1:0] a0;
    logic          r1;
    logic [IW-1:0] a1;
    logic          fv;
    logic          ft;
    logic [IW-1:0] fa;
    logic [DW-1:0] fd;
    logic [1:0]    eg;
    logic          eh;
    logic [DW-1:0] ed;
    logic [3:0]    rq;
  } vec_t;

  // r0 a0 r1 a1 | fill v tid ip data | exp grant hit data | req
  localparam vec_t VEC [22] = '{
    '{1'b1, 16'h0010, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0,    16'h0,    2'b01, 1'b0, 16'h0,    4'd4},  // R4 miss stalls t0
    '{1'b1, 16'h0010, 1'b0, 16'h0, 1'b1, 1'b0, 16'h0010, 16'hA001, 2'b00, 1'b0, 16'h0,    4'd4},  // R4 stalled, fill frees
    '{1'b1, 16'h0010, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0,    16'h0,    2'b01, 1'b1, 16'hA001, 4'd6},  // R6 hit data
    '{1'b0, 16'h0,    1'b1, 16'h0010, 1'b0, 1'b0, 16'h0, 16'h0,    2'b10, 1'b0, 16'h0,    4'd5},  // R5 owner mismatch
    '{1'b1, 16'h0010, 1'b1, 16'h0010, 1'b1, 1'b1, 16'h0010, 16'hB001, 2'b01, 1'b1, 16'hA001, 4'd4}, // R4 t1 stalled
    '{1'b1, 16'h0010, 1'b1, 16'h0010, 1'b0, 1'b0, 16'h0, 16'h0,    2'b10, 1'b1, 16'hB001, 4'd2},  // R2 alternate
    '{1'b1, 16'h0010, 1'b1, 16'h0010, 1'b0, 1'b0, 16'h0, 16'h0,    2'b01, 1'b1, 16'hA001, 4'd2},  // R2
    '{1'b1, 16'h0010, 1'b1, 16'h0010, 1'b0, 1'b0, 16'h0, 16'h0,    2'b10, 1'b1, 16'hB001, 4'd2},  // R2
    '{1'b0, 16'h0,    1'b0, 16'h0, 1'b1, 1'b0, 16'h0020, 16'hA002, 2'b00, 1'b0, 16'h0,    4'd8},  // R8 fill way 2
    '{1'b0, 16'h0,    1'b0, 16'h0, 1'b1, 1'b0, 16'h0030, 16'hA003, 2'b00, 1'b0, 16'h0,    4'd8},  // R8 fill way 3
    '{1'b1, 16'h0010, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0,    16'h0,    2'b01, 1'b1, 16'hA001, 4'd9},  // R9 refresh
    '{1'b0, 16'h0,    1'b0, 16'h0, 1'b1, 1'b0, 16'h0040, 16'hA004, 2'b00, 1'b0, 16'h0,    4'd9},  // R9 evict t1 line
    '{1'b0, 16'h0,    1'b1, 16'h0010, 1'b0, 1'b0, 16'h0, 16'h0,    2'b10, 1'b0, 16'h0,    4'd9},  // R9 t1 line gone
    '{1'b1, 16'h0040, 1'b1, 16'h0010, 1'b0, 1'b0, 16'h0, 16'h0,    2'b01, 1'b1, 16'hA004, 4'd4},  // R4 other gets slot
    '{1'b1, 16'h0020, 1'b1, 16'h0010, 1'b0, 1'b0, 16'h0, 16'h0,    2'b01, 1'b1, 16'hA002, 4'd3},  // R3 sole eligible
    '{1'b0, 16'h0,    1'b1, 16'h0010, 1'b1, 1'b0, 16'h0040, 16'hA0FF, 2'b00, 1'b0, 16'h0, 4'd4},  // R4 stalled ignored
    '{1'b1, 16'h0040, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0,    16'h0,    2'b01, 1'b1, 16'hA0FF, 4'd10}, // R10 overwrite
    '{1'b1, 16'h0030, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0,    16'h0,    2'b01, 1'b1, 16'hA003, 4'd10}, // R10 no eviction
    '{1'b1, 16'h0014, 1'b0, 16'h0, 1'b1, 1'b1, 16'h0014, 16'hB014, 2'b01, 1'b0, 16'h0,    4'd7},  // R7 set 1 empty
    '{1'b0, 16'h0,    1'b1, 16'h0014, 1'b1, 1'b0, 16'h0014, 16'hC014, 2'b10, 1'b1, 16'hB014, 4'd7}, // R7
    '{1'b1, 16'h0014, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0,    16'h0,    2'b01, 1'b1, 16'hC014, 4'd7},  // R7
    '{1'b1, 16'h0010, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0,    16'h0,    2'b01, 1'b1, 16'hA001, 4'd7}   // R7 set 0 intact
  };

  task automatic check(input string what, input int rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req0 = v.r0; ip0 = v.a0; req1 = v.r1; ip1 = v.a1;
    fill_vld = v.fv; fill_tid = v.ft; fill_ip = v.fa; fill_data = v.fd;
  endtask

  task automatic idle();
    req0 = 1'b0; req1 = 1'b0; fill_vld = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet outputs while in reset
    check("grant in reset", 1, DW'(grant), '0);
    check("hit in reset", 1, DW'(out_hit), '0);
    rst = 1'b0;
    @(negedge clk);
    check("grant after reset", 1, DW'(grant), '0);

    for (int i = 0; i < 22; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check($sformatf("vec %0d grant", i), int'(VEC[i].rq), DW'(grant), DW'(VEC[i].eg));
      check($sformatf("vec %0d hit", i), int'(VEC[i].rq), DW'(out_hit), DW'(VEC[i].eh));
      if (VEC[i].eh)
        check($sformatf("vec %0d data", i), int'(VEC[i].rq), out_data, VEC[i].ed);
    end

    // R1: mid-run reset clears lines and favours thread 0
    idle();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("grant during reset", 1, DW'(grant), '0);
    rst = 1'b0;
    req0 = 1'b1; ip0 = 16'h0010; req1 = 1'b1; ip1 = 16'h0014;
    @(negedge clk);
    check("first tie to t0", 1, DW'(grant), 16'h0001);
    check("lines invalid", 1, DW'(out_hit), '0);
    check("data zero on miss", 6, out_data, '0);
    // R4: t0 now stalled, t1 takes the slot
    @(negedge clk);
    check("t1 after t0 stall", 4, DW'(grant), 16'h0002);
    // R3: both stalled and no eligible request
    @(negedge clk);
    check("no eligible", 3, DW'(grant), '0);
    idle();
    @(negedge clk);
    check("idle no grant", 3, DW'(grant), '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule